// File: doc/BRIEF.md
# Missing Clock Detector

This block watches a monitored system clock from a separate, free-running reference clock and asks for a system reset when the monitored clock stops toggling. It samples the monitored clock's level through a synchronizer in the reference domain. Any change in the synchronized level counts as an edge. Each edge reloads a countdown timer.

If the level stays put, high or low, for the programmed number of reference cycles, the timer runs out. The block then raises a reset request and emits a single-cycle flag that names a lost clock as the reset cause. The limit is `TIMEOUT_CYC`. Its default of 1000 stands for 100 µs with a 10 MHz reference.

The request stays up until the monitored clock moves again. The enable comes from the reset controller, and this block never alters it. An enable that was set before the reset therefore still holds after the reset this block causes. The block drives only its internal reset request and touches no external reset pin. All of its ports are plain control and status signals. None of them carries a data stream, so there is no valid/ready handshake.

Top module: `clk_loss_detector`

## Requirements
- R1: While `ref_rst_n` is low, and on the first sampled reference cycles after its release, `rst_req` and `cause_pulse` are 0.
- R2: While `mon_clk` toggles with a half-period well below `TIMEOUT_CYC` reference cycles, `rst_req` stays 0 and `cause_pulse` never pulses.
- R3: With `enable` at 1 and `mon_clk` stuck low, `rst_req` rises no earlier than `TIMEOUT_CYC` and no later than `TIMEOUT_CYC + SYNC_STAGES + 3` reference cycles after the last `mon_clk` transition.
- R4: With `enable` at 1 and `mon_clk` stuck high, `rst_req` rises within the same window as in R3.
- R5: For each detection event, `cause_pulse` is high for exactly one reference cycle. That cycle is the cycle in which `rst_req` becomes 1.
- R6: `rst_req` stays 1 for as long as `mon_clk` stays stuck and `enable` stays 1, with no further `cause_pulse`.
- R7: When `mon_clk` changes level while `rst_req` is 1, `rst_req` returns to 0 within `SYNC_STAGES + 3` reference cycles.
- R8: While `enable` is 0, `rst_req` is 0 and `cause_pulse` does not pulse, however long `mon_clk` is stuck. Dropping `enable` while `rst_req` is 1 clears `rst_req` on the next reference cycle.
- R9: While `enable` is 0, the timer is held at its full reload value. When `enable` is later set to 1 with `mon_clk` already stuck, a full `TIMEOUT_CYC` window passes before `rst_req` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| enable | input | 1 | Detection enable from the reset controller, 1 = active |
| mon_clk | input | 1 | Monitored system clock, sampled as data |
| rst_req | output | 1 | Missing-clock reset request, held while the clock is stuck |
| cause_pulse | output | 1 | One-cycle flag marking a lost clock as the reset cause |

## Verification
Assertions inside the RTL check, on every cycle, several pulse and request rules. They check that the cause flag lasts a single cycle and only appears together with the request. They check that the request clears once the enable is gone or an edge is seen, and that it holds while the clock stays stuck. They also check that the timer never leaves its range. The timing window between the last transition and the request is shown only by the bench, which stops the monitored clock both high and low. The bench also shows that a toggling clock never alarms, and that re-enabling with the clock already stuck waits out a full timeout.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  // Alarm state of the detector
  typedef enum logic {
    ALM_IDLE  = 1'b0,
    ALM_FIRED = 1'b1
  } alarm_state_t;

  // Counter width that can hold the reload value
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/clkmon_level_sync.sv
module clkmon_level_sync #(
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic mon_clk,
  output logic edge_seen
);
  logic [STAGES-1:0] chain;
  logic              last_lvl;

  // Synchronizer stages, one flop per stage
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge ref_clk or negedge ref_rst_n) begin
          if (!ref_rst_n) chain[0] <= 1'b0;
          else            chain[0] <= mon_clk;
        end
      end else begin : g_next
        always_ff @(posedge ref_clk or negedge ref_rst_n) begin
          if (!ref_rst_n) chain[g] <= 1'b0;
          else            chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) last_lvl <= 1'b0;
    else            last_lvl <= chain[STAGES-1];
  end

  // Any level change of the synchronized clock is an edge
  assign edge_seen = chain[STAGES-1] ^ last_lvl;
endmodule

// File: rtl/clkmon_timeout.sv
module clkmon_timeout #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int CW          = clkmon_pkg::cnt_width(TIMEOUT_CYC)
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic enable,
  input  logic edge_seen,
  output logic expired
);
  localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n)                cnt <= RELOAD;
    else if (!enable || edge_seen) cnt <= RELOAD;
    else if (cnt != '0)            cnt <= cnt - CW'(1);
  end

  assign expired = enable && (cnt == '0);

  // R9
  cnt_bound_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    cnt <= RELOAD);

  // R3
  expire_no_edge_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (enable && $rose(expired)) |-> !$past(edge_seen));
endmodule

// File: rtl/clkmon_alarm.sv
module clkmon_alarm
  import clkmon_pkg::*;
(
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic enable,
  input  logic edge_seen,
  input  logic expired,
  output logic rst_req,
  output logic cause_pulse
);
  alarm_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ALM_IDLE:  if (enable && expired && !edge_seen) state_nx = ALM_FIRED;
      ALM_FIRED: if (!enable || edge_seen)             state_nx = ALM_IDLE;
      default:   state_nx = ALM_IDLE;
    endcase
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      state       <= ALM_IDLE;
      cause_pulse <= 1'b0;
    end else begin
      state       <= state_nx;
      cause_pulse <= (state == ALM_IDLE) && (state_nx == ALM_FIRED);
    end
  end

  assign rst_req = (state == ALM_FIRED);

  // R5
  pulse_with_req_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    cause_pulse |-> rst_req);

  // R5
  pulse_single_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    cause_pulse |=> !cause_pulse);

  // R8
  disabled_quiet_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !enable |=> !rst_req);

  // R7
  edge_release_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (rst_req && edge_seen) |=> !rst_req);

  // R6
  req_hold_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (rst_req && enable && !edge_seen) |=> (rst_req && !cause_pulse));
endmodule

// File: rtl/clk_loss_detector.sv
module clk_loss_detector #(
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic enable,
  input  logic mon_clk,
  output logic rst_req,
  output logic cause_pulse
);
  localparam int CW = clkmon_pkg::cnt_width(TIMEOUT_CYC);

  logic edge_seen;
  logic expired;

  clkmon_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .mon_clk   (mon_clk),
    .edge_seen (edge_seen)
  );

  clkmon_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)) u_timer (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .enable    (enable),
    .edge_seen (edge_seen),
    .expired   (expired)
  );

  clkmon_alarm u_alarm (
    .ref_clk     (ref_clk),
    .ref_rst_n   (ref_rst_n),
    .enable      (enable),
    .edge_seen   (edge_seen),
    .expired     (expired),
    .rst_req     (rst_req),
    .cause_pulse (cause_pulse)
  );
endmodule

// File: tb/test_clk_loss_detector.sv
module test_clk_loss_detector;
  localparam int TO = 32;
  localparam int SS = 2;

  logic ref_clk = 1'b0;
  logic ref_rst_n = 1'b0;
  logic enable = 1'b0;
  logic mon_clk = 1'b0;
  logic rst_req, cause_pulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int req_cycles = 0;
  bit done = 1'b0;

  always #2 ref_clk = ~ref_clk;

  clk_loss_detector #(.TIMEOUT_CYC(TO), .SYNC_STAGES(SS)) i_clk_loss_detector (
    .ref_clk     (ref_clk),
    .ref_rst_n   (ref_rst_n),
    .enable      (enable),
    .mon_clk     (mon_clk),
    .rst_req     (rst_req),
    .cause_pulse (cause_pulse)
  );

  always @(negedge ref_clk) begin
    if (cause_pulse) pulses++;
    if (rst_req)     req_cycles++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic toggle_mon(input int n);
    repeat (n) begin
      #20 mon_clk = ~mon_clk;
    end
  endtask

  task automatic clear_counts();
    @(negedge ref_clk);
    pulses = 0;
    req_cycles = 0;
  endtask

  task automatic t_reset();
    wait_ref(3);
    chk("R1 rst_req in reset", rst_req, 0);
    chk("R1 cause_pulse in reset", cause_pulse, 0);
    ref_rst_n = 1'b1;
    wait_ref(2);
    chk("R1 rst_req after reset", rst_req, 0);
    chk("R1 cause_pulse after reset", cause_pulse, 0);
  endtask

  task automatic t_running();
    enable = 1'b1;
    clear_counts();
    toggle_mon(200);
    chk("R2 request cycles while toggling", req_cycles, 0);
    chk("R2 pulses while toggling", pulses, 0);
  endtask

  task automatic t_stuck(input logic level, input string tag);
    if (mon_clk != level) toggle_mon(1);
    else toggle_mon(2);
    clear_counts();
    wait_ref(TO - 5);
    chk({tag, " early rst_req"}, rst_req, 0);
    wait_ref(13);
    chk({tag, " rst_req raised"}, rst_req, 1);
    chk("R5 one pulse per event", pulses, 1);
    wait_ref(3 * TO);
    chk("R6 rst_req held", rst_req, 1);
    chk("R6 no further pulse", pulses, 1);
    toggle_mon(1);
    wait_ref(SS + 4);
    chk("R7 released after edge", rst_req, 0);
    toggle_mon(20);
  endtask

  task automatic t_disabled();
    enable = 1'b0;
    toggle_mon(1);
    clear_counts();
    wait_ref(4 * TO);
    chk("R8 no request while disabled", req_cycles, 0);
    chk("R8 no pulse while disabled", pulses, 0);
    enable = 1'b1;
    wait_ref(TO - 3);
    chk("R9 full window after enable", rst_req, 0);
    wait_ref(8);
    chk("R9 request after enable window", rst_req, 1);
    enable = 1'b0;
    wait_ref(2);
    chk("R8 drop enable clears request", rst_req, 0);
    enable = 1'b1;
    toggle_mon(20);
    chk("R2 no request after resume", rst_req, 0);
  endtask

  initial begin
    t_reset();
    t_running();
    t_stuck(1'b0, "R3");
    t_stuck(1'b1, "R4");
    t_disabled();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule